// File: doc/BRIEF.md
# Two-Channel DC-Removal High-Pass Filter

This block strips the DC component from a stereo stream of 24-bit two's-complement audio samples. Each stereo frame carries one left and one right sample and is accepted through a valid/ready handshake. Each frame produces exactly one output frame, also with valid/ready. The filter is first order: it takes the difference of successive inputs and adds back a fraction of the previous output. A two-bit speed select picks the feedback coefficient. This keeps the -3 dB corner near 1 Hz whether the stream runs at 48, 96 or 192 kHz, and with that corner the response is down only about 0.1 dB near 6.5 Hz. The corner moves in proportion to the real sample rate within each family.

When the enable input is low, frames pass through with their values untouched. When it is high, the filtered result reaches the output two accepted frames later, which gives the enabled path a fixed two-frame latency. Enable and speed select are sampled together with each frame at the moment it is accepted. Back-pressure rules: an input frame is taken only in a cycle where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in that same cycle. While `out_valid` is high and `out_ready` is low, the output frame is held unchanged and no new input is taken.

Top module: `dc_block_hpf`

## Requirements
- R1: After reset, `out_valid` is low and `in_ready` is high. Both channel filter states and both delay lines are zero.
- R2: A frame accepted with `hpf_en` low is emitted with left and right equal to the input samples, in order.
- R3: A frame accepted with `hpf_en` high emits the filtered value computed two enabled frames earlier. The first two enabled outputs after reset or after a bypassed frame are zero.
- R4: The filtered value is y = x - xprev + floor(A*yprev / 2^24), with A = 2^24 - K. K is 2196 for speed code 00, 1098 for code 01 and 549 for code 10. xprev and yprev start at zero.
- R5: Speed code 11 uses the same coefficient as code 00.
- R6: The filtered value saturates at 7FFFFF hex and 800000 hex instead of wrapping. The saturated value is also the one fed back.
- R7: Left and right keep separate states. A sample in one channel never affects the other channel's output.
- R8: Each accepted frame yields one output frame with `out_valid` high in the next cycle. `in_ready` equals (not `out_valid`) or `out_ready`. A stalled output holds its data stable.
- R9: A bypassed frame clears the filter state and delay line of both channels, so that re-enabling starts from zero.
- R10: Enable and speed code are taken per frame at acceptance. A change of speed code between enabled frames switches the coefficient for the next frame only, and the state carries over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hpf_en | input | 1 | 1 = filter, 0 = bypass; sampled with each accepted frame |
| spd_mode | input | 2 | Speed code: 00 normal, 01 double, 10 quad, 11 treated as normal |
| in_valid | input | 1 | Input frame present |
| in_ready | output | 1 | Block can take an input frame |
| in_left | input | 24 | Left input sample, two's complement |
| in_right | input | 24 | Right input sample, two's complement |
| out_valid | output | 1 | Output frame present |
| out_ready | input | 1 | Downstream takes the output frame |
| out_left | output | 24 | Left output sample |
| out_right | output | 24 | Right output sample |

## Verification
Two things can land in the same cycle: a new frame is accepted, and the previously registered frame is drained. The bench provokes this by holding `in_valid` high back to back while `out_ready` is high. It also runs a deterministic stall pattern, so the drain-and-refill case alternates with held outputs. A scoreboard holds the expected frames, computed from the recurrence with per-frame enable and speed code. It judges that no frame is lost, duplicated or reordered, and that every value matches. Saturating steps between full-scale codes and bypass-then-enable sequences are placed inside these overlapping cycles.

// File: rtl/hpf_pkg.sv
package hpf_pkg;
  typedef enum logic [1:0] {
    SPD_NORMAL = 2'b00,
    SPD_DOUBLE = 2'b01,
    SPD_QUAD   = 2'b10,
    SPD_RSVD   = 2'b11
  } spd_mode_e;
endpackage

// File: rtl/hpf_coef_sel.sv
module hpf_coef_sel
  import hpf_pkg::*;
#(
  parameter int COEF_W   = 24,
  parameter int K_NORMAL = 2196,
  parameter int K_DOUBLE = 1098,
  parameter int K_QUAD   = 549
) (
  input  spd_mode_e          mode,
  output logic [COEF_W-1:0]  coef
);
  // coefficient is unity minus a small step, unity = 2^COEF_W
  localparam logic [COEF_W:0] UNITY = (COEF_W+1)'(1) << COEF_W;
  localparam logic [COEF_W-1:0] A_NORMAL = COEF_W'(UNITY - (COEF_W+1)'(K_NORMAL));
  localparam logic [COEF_W-1:0] A_DOUBLE = COEF_W'(UNITY - (COEF_W+1)'(K_DOUBLE));
  localparam logic [COEF_W-1:0] A_QUAD   = COEF_W'(UNITY - (COEF_W+1)'(K_QUAD));

  always_comb begin
    case (mode)
      SPD_DOUBLE: coef = A_DOUBLE;
      SPD_QUAD:   coef = A_QUAD;
      default:    coef = A_NORMAL;  // normal, and reserved code 11 (R5)
    endcase
  end
endmodule

// File: rtl/hpf_clamp.sv
module hpf_clamp #(
  parameter int IN_W  = 26,
  parameter int OUT_W = 24
) (
  input  logic signed [IN_W-1:0]  d,
  output logic signed [OUT_W-1:0] q
);
  localparam logic signed [OUT_W-1:0] OMAX = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic signed [OUT_W-1:0] OMIN = {1'b1, {(OUT_W-1){1'b0}}};
  localparam logic signed [IN_W-1:0]  WMAX = IN_W'(OMAX);
  localparam logic signed [IN_W-1:0]  WMIN = IN_W'(OMIN);

  always_comb begin
    if (d > WMAX)      q = OMAX;
    else if (d < WMIN) q = OMIN;
    else               q = OUT_W'(d);
  end
endmodule

// File: rtl/hpf_channel.sv
module hpf_channel #(
  parameter int DATA_W = 24,
  parameter int COEF_W = 24,
  parameter int LAT    = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     accept,
  input  logic                     en,
  input  logic [COEF_W-1:0]        coef,
  input  logic signed [DATA_W-1:0] x,
  output logic signed [DATA_W-1:0] res
);
  localparam int PROD_W = DATA_W + COEF_W + 1;
  localparam int SUM_W  = DATA_W + 2;

  logic signed [DATA_W-1:0] xp, yp;
  logic signed [DATA_W-1:0] dly [LAT];
  logic signed [PROD_W-1:0] prod;
  logic signed [SUM_W-1:0]  fb, sum;
  logic signed [DATA_W-1:0] y;

  always_comb begin
    prod = PROD_W'(yp) * PROD_W'($signed({1'b0, coef}));
    fb   = SUM_W'(prod >>> COEF_W);
    sum  = SUM_W'(x) - SUM_W'(xp) + fb;
  end

  hpf_clamp #(.IN_W(SUM_W), .OUT_W(DATA_W)) u_clamp (
    .d (sum),
    .q (y)
  );

  assign res = en ? dly[LAT-1] : x;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xp <= '0;
      yp <= '0;
      for (int i = 0; i < LAT; i++) dly[i] <= '0;
    end else if (accept) begin
      if (en) begin
        xp     <= x;
        yp     <= y;
        dly[0] <= y;
        for (int i = 1; i < LAT; i++) dly[i] <= dly[i-1];
      end else begin
        xp <= '0;
        yp <= '0;
        for (int i = 0; i < LAT; i++) dly[i] <= '0;
      end
    end
  end
endmodule

// File: rtl/dc_block_hpf.sv
module dc_block_hpf
  import hpf_pkg::*;
#(
  parameter int DATA_W   = 24,
  parameter int COEF_W   = 24,
  parameter int LAT      = 2,
  parameter int K_NORMAL = 2196,
  parameter int K_DOUBLE = 1098,
  parameter int K_QUAD   = 549
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hpf_en,
  input  logic [1:0]        spd_mode,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_left,
  input  logic [DATA_W-1:0] in_right,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_left,
  output logic [DATA_W-1:0] out_right
);
  localparam int NCH = 2;

  logic              accept;
  logic [COEF_W-1:0] coef;
  logic signed [DATA_W-1:0] x_ch   [NCH];
  logic signed [DATA_W-1:0] res_ch [NCH];

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign x_ch[0]  = in_left;
  assign x_ch[1]  = in_right;

  hpf_coef_sel #(
    .COEF_W(COEF_W), .K_NORMAL(K_NORMAL), .K_DOUBLE(K_DOUBLE), .K_QUAD(K_QUAD)
  ) u_coef (
    .mode (spd_mode_e'(spd_mode)),
    .coef (coef)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    hpf_channel #(.DATA_W(DATA_W), .COEF_W(COEF_W), .LAT(LAT)) u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .accept (accept),
      .en     (hpf_en),
      .coef   (coef),
      .x      (x_ch[ch]),
      .res    (res_ch[ch])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_left  <= '0;
      out_right <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_left  <= res_ch[0];
      out_right <= res_ch[1];
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/dc_block_hpf_sva.sv
module dc_block_hpf_sva #(
  parameter int DATA_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hpf_en,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] in_left,
  input logic [DATA_W-1:0] in_right,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_left,
  input logic [DATA_W-1:0] out_right
);
  // R1: reset empties the output register
  a_r1_reset_empty: assert property (@(posedge clk)
    !rst_n |=> !out_valid);

  // R8: an accepted frame shows up in the next cycle
  a_r8_frame_emitted: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R8: a stalled output keeps its data
  a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_left) && $stable(out_right));

  // R8: draining with nothing new leaves the register empty
  a_r8_drain_empty: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid);

  // R2: a bypassed frame comes out unchanged
  a_r2_bypass_value: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !hpf_en |=>
      out_left == $past(in_left) && out_right == $past(in_right));
endmodule

bind dc_block_hpf dc_block_hpf_sva #(.DATA_W(DATA_W)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .hpf_en    (hpf_en),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_left   (in_left),
  .in_right  (in_right),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_left  (out_left),
  .out_right (out_right)
);

// File: tb/dc_block_hpf_test.sv
`timescale 1ns/1ps
module dc_block_hpf_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hpf_en = 1'b0;
  logic [1:0]  spd_mode = 2'b00;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [23:0] in_left = '0, in_right = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [23:0] out_left, out_right;

  int n_checks = 0;
  int n_fails  = 0;
  bit backpress = 1'b0;
  bit done = 1'b0;

  logic [47:0] q_exp [$];
  string       q_tag [$];

  int m_xp [2];
  int m_yp [2];
  int m_d0 [2];
  int m_d1 [2];

  always #4 clk = ~clk;

  dc_block_hpf uut (
    .clk(clk), .rst_n(rst_n), .hpf_en(hpf_en), .spd_mode(spd_mode),
    .in_valid(in_valid), .in_ready(in_ready), .in_left(in_left), .in_right(in_right),
    .out_valid(out_valid), .out_ready(out_ready), .out_left(out_left), .out_right(out_right)
  );

  function automatic int sx24(input logic [23:0] v);
    return int'($signed(v));
  endfunction

  // reference recurrence from the requirements (R4, R5, R6)
  function automatic int model_step(input int ch, input int x, input bit en, input int mode);
    longint a, p, s;
    int k, y, res;
    if (!en) begin
      m_xp[ch] = 0; m_yp[ch] = 0; m_d0[ch] = 0; m_d1[ch] = 0;
      return x;
    end
    k = (mode == 1) ? 1098 : (mode == 2) ? 549 : 2196;
    a = (longint'(1) << 24) - longint'(k);
    p = longint'(m_yp[ch]) * a;
    s = longint'(x) - longint'(m_xp[ch]) + (p >>> 24);
    if (s > 8388607) y = 8388607;
    else if (s < -8388608) y = -8388608;
    else y = int'(s);
    res = m_d1[ch];
    m_d1[ch] = m_d0[ch];
    m_d0[ch] = y;
    m_xp[ch] = x;
    m_yp[ch] = y;
    return res;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [47:0] act, input logic [47:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic send(input int l, input int r, input bit en, input int mode, input string tag);
    bit acc;
    int el, er;
    acc = 1'b0;
    @(negedge clk);
    in_valid = 1'b1;
    in_left  = l[23:0];
    in_right = r[23:0];
    hpf_en   = en;
    spd_mode = mode[1:0];
    forever begin
      #3;
      if (in_ready) begin
        acc = 1'b1;
        el = model_step(0, sx24(l[23:0]), en, mode);
        er = model_step(1, sx24(r[23:0]), en, mode);
        q_exp.push_back({el[23:0], er[23:0]});
        q_tag.push_back(tag);
      end
      @(posedge clk);
      if (acc) break;
      @(negedge clk);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor: drives out_ready and compares drained frames
  initial begin
    int cyc;
    logic [47:0] e;
    string t;
    cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      out_ready = backpress ? ((cyc % 3) != 1) : 1'b1;
      #3;
      if (rst_n && out_valid && out_ready) begin
        if (q_exp.size() == 0) begin
          check(1'b0, "R8", "unexpected output frame", {out_left, out_right}, '0);
        end else begin
          e = q_exp.pop_front();
          t = q_tag.pop_front();
          check({out_left, out_right} == e, t, "frame", {out_left, out_right}, e);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL R8 watchdog expired: actual %0d pending expected 0", q_exp.size());
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 2; c++) begin
      m_xp[c] = 0; m_yp[c] = 0; m_d0[c] = 0; m_d1[c] = 0;
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #3;
    // R1: empty output, ready input
    check(out_valid == 1'b0, "R1", "out_valid after reset", 48'(out_valid), 48'd0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", 48'(in_ready), 48'd1);

    // R1 R3: first enabled outputs after reset are zero
    send(32'h000100, 32'h000200, 1'b1, 0, "R1 R3");
    send(32'h000100, 32'h000200, 1'b1, 0, "R1 R3");

    // R2: bypass keeps values, including full scale codes
    send(32'h7FFFFF, 32'h800000, 1'b0, 0, "R2");
    send(32'h123456, 32'hFEDCBA, 1'b0, 1, "R2");
    send(32'h000000, 32'h000001, 1'b0, 2, "R2");
    send(32'hABCDEF, 32'h7FFFFF, 1'b0, 3, "R2");

    // R3 R4 R7: step on left, different ramp on right, normal speed
    for (int i = 0; i < 12; i++)
      send(32'h200000, -1000 * i, 1'b1, 0, "R3 R4 R7");

    // R8: stalls under back-pressure while modes change
    backpress = 1'b1;
    for (int i = 0; i < 8; i++)
      send(32'h300000 - i * 4096, 32'h050000, 1'b1, 1, "R4 R8");
    for (int i = 0; i < 8; i++)
      send(-32'h250000, 32'h010000 + i, 1'b1, 2, "R4 R8");
    // R5: reserved code behaves like normal
    for (int i = 0; i < 6; i++)
      send(32'h400000, -32'h400000, 1'b1, 3, "R5");

    // R10: speed code alternates frame by frame
    for (int i = 0; i < 9; i++)
      send(32'h100000 * (i % 3), 32'h0F0000, 1'b1, i % 3, "R10");

    // R9: bypass then re-enable starts from zero
    send(32'h111111, 32'h222222, 1'b0, 0, "R9");
    send(32'h333333, 32'h044444, 1'b1, 0, "R9");
    send(32'h333333, 32'h044444, 1'b1, 0, "R9");
    send(32'h333333, 32'h044444, 1'b1, 0, "R9");
    backpress = 1'b0;

    // R6: full-scale swings saturate both ways
    send(32'h000000, 32'h000000, 1'b0, 0, "R6");
    send(32'h800000, 32'h7FFFFF, 1'b1, 1, "R6");
    send(32'h7FFFFF, 32'h800000, 1'b1, 1, "R6");
    send(32'h800000, 32'h7FFFFF, 1'b1, 1, "R6");
    send(32'h7FFFFF, 32'h800000, 1'b1, 1, "R6");
    send(32'h7FFFFF, 32'h800000, 1'b1, 1, "R6");
    send(32'h7FFFFF, 32'h800000, 1'b1, 1, "R6");
    idle();

    for (int w = 0; w < 50 && q_exp.size() != 0; w++) @(posedge clk);
    check(q_exp.size() == 0, "R8", "frames left undelivered", 48'(q_exp.size()), 48'd0);
    @(negedge clk);
    check(out_valid == 1'b0, "R8", "output empty after drain", 48'(out_valid), 48'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule